// File: doc/BRIEF.md
# Trace Port Packet Formatter

The formatter sits between a core-side trace producer and a narrow off-chip trace port. The producer hands over 8-bit trace packets one at a time. Each packet carries a flag that marks it as the first packet of a branch-address group. Packets wait in a ten-entry byte FIFO. The formatter then sends each one out over two beats of a 4-bit nibble bus, low half first. A sync strobe runs beside the nibbles and marks the packets that open a branch address. A 3-bit pipeline-status value is taken from the core on every beat and passed to the port.

All port outputs are registered and change only on a rising clock edge. A half-rate select makes the outputs advance on every second clock instead of on every clock. This suits a trace clock that runs at half the system rate. When the FIFO holds ten packets, a full flag tells the producer to hold off. A write made while the flag is high is discarded. The nibble bus carries zero whenever there is nothing to send, and status keeps flowing.

Top module: `tpkt_formatter`

## Requirements
- R1: A stored packet is sent over two consecutive beats: bits [3:0] on `trc_nibble` in the first beat and bits [7:4] in the second.
- R2: `trc_sync` is 1 during both beats of a packet written with `pkt_brst` = 1, and 0 during both beats of any other packet.
- R3: On every beat, `trc_stat` takes the value present on `pipe_stat` at the clock edge of that beat, whether or not a packet is being sent.
- R4: When a new packet would start but the FIFO is empty, the beat drives `trc_nibble` = 0 and `trc_sync` = 0.
- R5: With `half_rate` = 1, a beat happens only on every second clock. `trc_nibble`, `trc_sync` and `trc_stat` hold their values on the clocks in between. With `half_rate` = 0, every clock is a beat. After reset, or after `half_rate` rises, the first half-rate beat is the second clock edge.
- R6: `fifo_full` is 1 exactly while ten packets are stored.
- R7: A write presented while `fifo_full` = 1 is dropped. The stored packets and their order are unchanged.
- R8: While `rst_n` = 0, the FIFO is empty, the next beat sends a low nibble, and `trc_nibble`, `trc_stat`, `trc_sync` and `fifo_full` are all 0.
- R9: Packets leave in the order in which they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every output changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronous to clk |
| pkt_valid | input | 1 | Write strobe for one packet in this cycle |
| pkt_byte | input | 8 | Trace packet to store |
| pkt_brst | input | 1 | Marks the packet as the first of a branch-address group |
| pipe_stat | input | 3 | Pipeline status from the core, sampled on each beat |
| half_rate | input | 1 | 1: outputs advance on every second clock; 0: on every clock |
| trc_nibble | output | 4 | Trace nibble bus |
| trc_stat | output | 3 | Registered pipeline status |
| trc_sync | output | 1 | Branch-address group start strobe |
| fifo_full | output | 1 | Ten packets stored; further writes are dropped |

## Verification
The assertions assume the following about the inputs:
- `rst_n` is released in step with `clk`.
- The data inputs settle between clock edges.
- `half_rate` may change at any clock.

The stimulus changes every input on the falling edge. It releases reset on a falling edge as well. It switches `half_rate` only between test phases. It also writes every clock in half-rate mode, so that the FIFO fills and writes are refused while full. The property that the serializer never pops an empty FIFO depends on the FIFO and serializer staying in step. The phase check inside the serializer guards that.

// File: rtl/tpkt_pkg.sv
package tpkt_pkg;
  localparam int unsigned PKT_W  = 8;
  localparam int unsigned BEAT_W = PKT_W / 2;
  localparam int unsigned STAT_W = 3;

  typedef struct packed {
    logic             brst;
    logic [PKT_W-1:0] data;
  } tpkt_entry_t;
endpackage

// File: rtl/tpkt_fifo.sv
module tpkt_fifo
  import tpkt_pkg::*;
#(
  parameter int unsigned DEPTH = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_req,
  input  tpkt_entry_t wr_ent,
  input  logic        rd_ack,
  output tpkt_entry_t head,
  output logic        empty,
  output logic        full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [PW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_en, rd_en;
  tpkt_entry_t   mem [DEPTH];

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign head  = mem[rd_ptr_q];

  always_comb begin
    wr_en    = wr_req && !full;
    rd_en    = rd_ack && !empty;
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (wr_en) begin
      wr_ptr_d = (wr_ptr_q == PW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    end
    if (rd_en) begin
      rd_ptr_d = (rd_ptr_q == PW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    end
    case ({wr_en, rd_en})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en && (wr_ptr_q == PW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[i] <= '0;
      end else if (slot_we) begin
        mem[i] <= wr_ent;
      end
    end
  end

  // R6: occupancy never exceeds the depth
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R7: a refused write leaves the FIFO full and its head untouched
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_req && !rd_ack) |=> (full && $stable(head)));

  // R9: the reader never consumes from an empty FIFO
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> !empty);
endmodule

// File: rtl/tpkt_beat_gen.sv
module tpkt_beat_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic half_rate,
  output logic beat_en
);
  logic tgl_q, tgl_d;

  always_comb begin
    tgl_d   = half_rate && !tgl_q;
    beat_en = !half_rate || tgl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_q <= 1'b0;
    end else begin
      tgl_q <= tgl_d;
    end
  end

  // R5: in half-rate mode a beat is never followed by another beat
  p_half_alt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (half_rate && beat_en) |=> (!half_rate || !beat_en));

  // R5: in half-rate mode an idle clock is always followed by a beat
  p_half_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (half_rate && !beat_en) |=> beat_en);
endmodule

// File: rtl/tpkt_serializer.sv
module tpkt_serializer
  import tpkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_en,
  input  logic [STAT_W-1:0] stat_in,
  input  tpkt_entry_t       head,
  input  logic              empty,
  output logic              rd_ack,
  output logic [BEAT_W-1:0] nib_o,
  output logic [STAT_W-1:0] stat_o,
  output logic              sync_o
);
  logic              phase_q, phase_d;
  logic [BEAT_W-1:0] nib_q, nib_d;
  logic [STAT_W-1:0] stat_q, stat_d;
  logic              sync_q, sync_d;

  always_comb begin
    phase_d = phase_q;
    nib_d   = nib_q;
    stat_d  = stat_q;
    sync_d  = sync_q;
    rd_ack  = 1'b0;
    if (beat_en) begin
      stat_d = stat_in;
      if (!phase_q) begin
        if (!empty) begin
          nib_d   = head.data[BEAT_W-1:0];
          sync_d  = head.brst;
          phase_d = 1'b1;
        end else begin
          nib_d  = '0;
          sync_d = 1'b0;
        end
      end else begin
        nib_d   = head.data[PKT_W-1:BEAT_W];
        sync_d  = head.brst;
        phase_d = 1'b0;
        rd_ack  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      nib_q   <= '0;
      stat_q  <= '0;
      sync_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      nib_q   <= nib_d;
      stat_q  <= stat_d;
      sync_q  <= sync_d;
    end
  end

  assign nib_o  = nib_q;
  assign stat_o = stat_q;
  assign sync_o = sync_q;

  // R1: the high-nibble beat always has a packet at the head
  p_phase_head_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q |-> !empty);

  // R2: the second beat of a packet keeps the sync level of the first
  p_sync_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_en && phase_q) |=> $stable(sync_o));

  // R4: an empty start beat drives a zero nibble and no sync
  p_empty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_en && !phase_q && empty) |=> (nib_o == '0 && !sync_o));

  // R5: the port outputs hold between beats
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_en |=> ($stable(nib_o) && $stable(sync_o) && $stable(stat_o)));
endmodule

// File: rtl/tpkt_formatter.sv
module tpkt_formatter
  import tpkt_pkg::*;
#(
  parameter int unsigned DEPTH = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  input  logic [PKT_W-1:0]  pkt_byte,
  input  logic              pkt_brst,
  input  logic [STAT_W-1:0] pipe_stat,
  input  logic              half_rate,
  output logic [BEAT_W-1:0] trc_nibble,
  output logic [STAT_W-1:0] trc_stat,
  output logic              trc_sync,
  output logic              fifo_full
);
  tpkt_entry_t wr_ent, head;
  logic        empty, rd_ack, beat_en;

  assign wr_ent.brst = pkt_brst;
  assign wr_ent.data = pkt_byte;

  tpkt_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_req (pkt_valid),
    .wr_ent (wr_ent),
    .rd_ack (rd_ack),
    .head   (head),
    .empty  (empty),
    .full   (fifo_full)
  );

  tpkt_beat_gen u_beat (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_rate (half_rate),
    .beat_en   (beat_en)
  );

  tpkt_serializer u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .beat_en (beat_en),
    .stat_in (pipe_stat),
    .head    (head),
    .empty   (empty),
    .rd_ack  (rd_ack),
    .nib_o   (trc_nibble),
    .stat_o  (trc_stat),
    .sync_o  (trc_sync)
  );
endmodule

// File: tb/tpkt_formatter_bench.sv
module tpkt_formatter_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pkt_valid;
  logic [7:0] pkt_byte;
  logic       pkt_brst;
  logic [2:0] pipe_stat;
  logic       half_rate;
  logic [3:0] trc_nibble;
  logic [2:0] trc_stat;
  logic       trc_sync;
  logic       fifo_full;

  int checks = 0;
  int errors = 0;
  string ctx = "R8";

  always #10 clk = ~clk;

  tpkt_formatter u_tpkt_formatter (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_byte(pkt_byte),
    .pkt_brst(pkt_brst), .pipe_stat(pipe_stat), .half_rate(half_rate),
    .trc_nibble(trc_nibble), .trc_stat(trc_stat), .trc_sync(trc_sync),
    .fifo_full(fifo_full)
  );

  // Behavioural expectation built from the requirements: queue of {brst, byte}
  logic [8:0] mq[$];
  logic       m_ph, m_tgl, m_beat, m_was_full;
  logic [3:0] m_nib;
  logic [2:0] m_stat;
  logic       m_sync;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      m_ph = 1'b0; m_tgl = 1'b0; m_nib = '0; m_stat = '0; m_sync = 1'b0;
    end else begin
      m_was_full = (mq.size() == 10);
      m_beat = !half_rate || m_tgl;
      if (m_beat) begin
        m_stat = pipe_stat;
        if (!m_ph) begin
          if (mq.size() > 0) begin
            m_nib = mq[0][3:0]; m_sync = mq[0][8]; m_ph = 1'b1;
          end else begin
            m_nib = '0; m_sync = 1'b0;
          end
        end else begin
          m_nib = mq[0][7:4]; m_sync = mq[0][8]; m_ph = 1'b0;
          void'(mq.pop_front());
        end
      end
      if (pkt_valid && !m_was_full) mq.push_back({pkt_brst, pkt_byte});
      m_tgl = half_rate ? !m_tgl : 1'b0;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", ctx, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("nibble R1 R9", int'(trc_nibble), int'(m_nib));
    chk("sync R2", int'(trc_sync), int'(m_sync));
    chk("status R3", int'(trc_stat), int'(m_stat));
    chk("full R6", int'(fifo_full), int'(mq.size() == 10));
  endtask

  task automatic cyc(input logic v, input logic [7:0] b, input logic br,
                     input logic [2:0] st);
    pkt_valid = v; pkt_byte = b; pkt_brst = br; pipe_stat = st;
    @(negedge clk);
    compare_all();
  endtask

  // {valid, brst, stat[2:0], byte[7:0]}
  localparam int NV = 12;
  localparam logic [12:0] VEC [NV] = '{
    13'h1_A5A, 13'h0_1C3, 13'h0_27E, 13'h1_B01, 13'h0_4FF, 13'h0_000,
    13'h0_6F0, 13'h1_D96, 13'h1_E42, 13'h0_200, 13'h1_33C, 13'h0_5E7
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pkt_valid = 0; pkt_byte = 0; pkt_brst = 0;
    pipe_stat = 3'd5; half_rate = 0;
    repeat (3) @(negedge clk);
    ctx = "R8 reset";
    chk("nibble", int'(trc_nibble), 0);
    chk("status", int'(trc_stat), 0);
    chk("sync", int'(trc_sync), 0);
    chk("full", int'(fifo_full), 0);
    rst_n = 1'b1;

    // Table walk, full rate then half rate
    for (int pass = 0; pass < 2; pass++) begin
      half_rate = (pass == 1);
      ctx = pass ? "R5 half" : "R1 R2 R3 table";
      for (int i = 0; i < NV; i++)
        cyc(VEC[i][12], VEC[i][7:0], VEC[i][11], VEC[i][10:8]);
      ctx = "R4 drain";
      for (int i = 0; i < 40; i++) cyc(1'b0, 8'h00, 1'b0, 3'(i));
      chk("R4 idle nibble", int'(trc_nibble), 0);
      chk("R4 idle sync", int'(trc_sync), 0);
    end

    // Fill in half-rate mode: writes every clock outrun the drain
    begin
      bit saw_full = 0;
      ctx = "R6 R7 fill";
      for (int i = 0; i < 24; i++) begin
        cyc(1'b1, 8'h30 + 8'(i), (i % 5) == 0, 3'(7 - (i % 8)));
        if (fifo_full) saw_full = 1;
      end
      chk("R6 full reached", int'(saw_full), 1);
      ctx = "R7 R9 drain after drops";
      for (int i = 0; i < 60; i++) cyc(1'b0, 8'hEE, 1'b1, 3'(i));
      chk("R4 empty after drain", int'(trc_nibble), 0);
    end

    // Reset in mid-stream
    ctx = "R8 mid";
    half_rate = 0;
    for (int i = 0; i < 3; i++) cyc(1'b1, 8'h9C, 1'b1, 3'd6);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 nibble", int'(trc_nibble), 0);
    chk("R8 sync", int'(trc_sync), 0);
    chk("R8 stat", int'(trc_stat), 0);
    chk("R8 full", int'(fifo_full), 0);
    rst_n = 1'b1;
    ctx = "R8 after";
    cyc(1'b1, 8'h4B, 1'b0, 3'd2);
    for (int i = 0; i < 4; i++) cyc(1'b0, 8'h00, 1'b0, 3'd1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule